// File: doc/BRIEF.md
# Banked GPIO Controller

A 32-pin general purpose I/O controller sitting on a plain memory-mapped register port. The pins are grouped into four banks of eight. Pin n belongs to bank n>>3 and uses bit n&7 of that bank's registers. Each bank owns a 0x40-byte register window at offset bank*0x40.

Within a bank, software can do the following:
- steer each pin between driving and listening;
- hold the value driven on output pins;
- read the synchronized pin levels;
- arm per-pin interrupts of edge or level type.

Interrupts are masked and unmasked through two separate write addresses, so a single write never needs a read-modify-write. Edge status is acknowledged by writing ones. All masked status bits from every bank combine into one interrupt line.

Pins are presented in a tristate-ready form: a drive value, an output-enable and a sampled input, for an external pad cell.

Top module: `banked_gpio`

## Requirements
- R1: After reset every pin is an input (direction register 0xFF, pin_oe all 0), output latches are 0, all masks are 0xFF, raw status is 0, all pins are edge type and irq is 0.
- R2: Pin n is controlled by bit n&7 of the bank at address (n>>3)*0x40; for example, pin 10 is bit 2 of bank 1.
- R3: The direction register at bank offset 0x10 reads back as written; a 1 bit makes the pin an input (pin_oe=0) and a 0 bit makes it an output (pin_oe=1). pin_oe changes only after a bus write.
- R4: The output latch at bank offset 0x14 reads back as written and drives pin_out; pin_out changes only after a bus write.
- R5: Bank offset 0x18 reads the pin levels through a two-flop synchronizer. A level change is first seen by a read whose strobe edge is the third rising edge after the change. Writes to 0x18 are ignored.
- R6: For an edge-type pin, a rising edge of its synchronized input sets its raw status bit (bank offset 0x04). The bit stays set after the input falls until a write to 0x04 carries a 1 in that bit position; 0 bits in that write leave status alone.
- R7: Interrupt type at bank offset 0x20 reads back as written, with 1 meaning level type. A level-type pin's raw status follows its synchronized level: a clear write has no effect while the level is high, and the bit drops when the level goes low.
- R8: Bank offset 0x08 reads the mask; writing it sets the mask bits given as 1. Writing bank offset 0x0C clears the mask bits given as 1, and 0x0C reads as zero.
- R9: Bank offset 0x00 reads raw status AND NOT mask, and ignores writes.
- R10: irq is the OR of the masked status of all four banks; with every mask bit set irq is 0.
- R11: Read data bits 31:8 are always zero. Unmapped or unaligned offsets read as zero and writes to them change no register.
- R12: bus_rdata is registered: it updates at the clock edge where bus_sel is high and bus_wr is low, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_sel | input | 1 | Access strobe, one access per cycle it is high |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data (bits 7:0 used) |
| bus_rdata | output | 32 | Registered read data |
| pin_out | output | 32 | Value to drive on each pin |
| pin_oe | output | 32 | Per-pin output enable |
| pin_in | input | 32 | Pin levels from the pads |
| irq | output | 1 | Combined interrupt |

## Verification
Writes take effect at the edge of their strobe, so registers are read back by the next access. Read data is sampled at the falling edge after the read strobe's rising edge. A pin change reaches the input register on the second edge and raw status and irq on the third. The bench therefore issues three back-to-back reads after a change and expects old, old, new. It also checks irq low at the second falling edge and high at the third. Other interrupt checks wait four cycles after the pin moves before sampling, and irq after an acknowledgement is checked at the falling edge that ends the write.

// File: rtl/banked_gpio_pkg.sv
`timescale 1ns/1ps
package banked_gpio_pkg;
   // Register offsets inside one bank window (software-visible layout)
   localparam logic [5:0] OFF_MSTAT = 6'h00;
   localparam logic [5:0] OFF_RAW   = 6'h04;
   localparam logic [5:0] OFF_MSET  = 6'h08;
   localparam logic [5:0] OFF_MCLR  = 6'h0C;
   localparam logic [5:0] OFF_DIR   = 6'h10;
   localparam logic [5:0] OFF_OUT   = 6'h14;
   localparam logic [5:0] OFF_IN    = 6'h18;
   localparam logic [5:0] OFF_LVL   = 6'h20;
endpackage

// File: rtl/banked_gpio_sync.sv
`timescale 1ns/1ps
module banked_gpio_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] st [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) st[i] <= '0;
            end else begin
               st[0] <= d;
               for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
            end
         end
         assign q = st[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/banked_gpio_bank.sv
`timescale 1ns/1ps
module banked_gpio_bank #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_dir,
   input  logic         wr_out,
   input  logic         wr_mset,
   input  logic         wr_mclr,
   input  logic         wr_ack,
   input  logic         wr_lvl,
   input  logic [W-1:0] wbyte,
   input  logic [W-1:0] level_in,
   output logic [W-1:0] dir_q,
   output logic [W-1:0] out_q,
   output logic [W-1:0] mask_q,
   output logic [W-1:0] lvl_q,
   output logic [W-1:0] raw_q
);
   logic [W-1:0] prev_q;
   logic [W-1:0] ack_v;
   logic [W-1:0] raw_d;

   assign ack_v = wr_ack ? wbyte : '0;
   // level pins follow the level, edge pins latch rising edges until acknowledged
   assign raw_d = (lvl_q & level_in)
                | (~lvl_q & ((raw_q & ~ack_v) | (level_in & ~prev_q)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q  <= '1;
         out_q  <= '0;
         mask_q <= '1;
         lvl_q  <= '0;
         raw_q  <= '0;
         prev_q <= '0;
      end else begin
         if (wr_dir) dir_q <= wbyte;
         if (wr_out) out_q <= wbyte;
         if (wr_lvl) lvl_q <= wbyte;
         if (wr_mset)      mask_q <= mask_q | wbyte;
         else if (wr_mclr) mask_q <= mask_q & ~wbyte;
         raw_q  <= raw_d;
         prev_q <= level_in;
      end
   end
endmodule

// File: rtl/banked_gpio.sv
`timescale 1ns/1ps
module banked_gpio
   import banked_gpio_pkg::*;
#(
   parameter int NUM_BANKS   = 4,
   parameter int BANK_W      = 8,
   parameter int STRIDE_LOG2 = 6,
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        bus_sel,
   input  logic                        bus_wr,
   input  logic [ADDR_W-1:0]           bus_addr,
   input  logic [DATA_W-1:0]           bus_wdata,
   output logic [DATA_W-1:0]           bus_rdata,
   output logic [NUM_BANKS*BANK_W-1:0] pin_out,
   output logic [NUM_BANKS*BANK_W-1:0] pin_oe,
   input  logic [NUM_BANKS*BANK_W-1:0] pin_in,
   output logic                        irq
);
   localparam int NUM_PINS = NUM_BANKS * BANK_W;
   localparam int SEL_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
   localparam int DEC_W    = STRIDE_LOG2 + SEL_W;

   // elaboration-time parameter checks
   generate
      if (NUM_BANKS < 2 || (1 << SEL_W) != NUM_BANKS) begin : g_bad_banks
         $error("NUM_BANKS must be a power of two of at least 2");
      end
      if (BANK_W < 1 || BANK_W > DATA_W) begin : g_bad_width
         $error("BANK_W must lie in 1..DATA_W");
      end
      if (STRIDE_LOG2 < 6) begin : g_bad_stride
         $error("bank window must hold offsets up to 0x3F");
      end
      if (ADDR_W < DEC_W) begin : g_bad_addr
         $error("ADDR_W too small for the bank map");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("SYNC_STAGES must not be negative");
      end
   endgenerate

   logic [STRIDE_LOG2-1:0] off;
   logic [SEL_W-1:0]       bank_idx;
   logic                   in_map;
   logic                   is_wr;
   logic [BANK_W-1:0]      wbyte;
   logic [NUM_PINS-1:0]    pin_sync;
   logic [NUM_PINS-1:0]    mask_flat;
   logic [NUM_PINS-1:0]    mstat_flat;
   logic [BANK_W-1:0]      rd_byte;

   logic [BANK_W-1:0] dir_a   [NUM_BANKS];
   logic [BANK_W-1:0] out_a   [NUM_BANKS];
   logic [BANK_W-1:0] mask_a  [NUM_BANKS];
   logic [BANK_W-1:0] lvl_a   [NUM_BANKS];
   logic [BANK_W-1:0] raw_a   [NUM_BANKS];
   logic [BANK_W-1:0] mstat_a [NUM_BANKS];
   logic [BANK_W-1:0] in_a    [NUM_BANKS];

   assign off      = bus_addr[STRIDE_LOG2-1:0];
   assign bank_idx = bus_addr[DEC_W-1:STRIDE_LOG2];
   assign wbyte    = bus_wdata[BANK_W-1:0];
   assign is_wr    = bus_sel && bus_wr && in_map;

   generate
      if (ADDR_W > DEC_W) begin : g_hi_addr
         assign in_map = (bus_addr[ADDR_W-1:DEC_W] == '0);
      end else begin : g_full_addr
         assign in_map = 1'b1;
      end
      if (DATA_W > BANK_W) begin : g_wide_data
         logic unused_wdata_hi;
         assign unused_wdata_hi = ^bus_wdata[DATA_W-1:BANK_W];
      end
   endgenerate

   banked_gpio_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (pin_sync)
   );

   generate
      for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
         logic hit;
         assign hit = is_wr && (bank_idx == SEL_W'(k));

         banked_gpio_bank #(.W(BANK_W)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_dir   (hit && off == STRIDE_LOG2'(OFF_DIR)),
            .wr_out   (hit && off == STRIDE_LOG2'(OFF_OUT)),
            .wr_mset  (hit && off == STRIDE_LOG2'(OFF_MSET)),
            .wr_mclr  (hit && off == STRIDE_LOG2'(OFF_MCLR)),
            .wr_ack   (hit && off == STRIDE_LOG2'(OFF_RAW)),
            .wr_lvl   (hit && off == STRIDE_LOG2'(OFF_LVL)),
            .wbyte    (wbyte),
            .level_in (pin_sync[k*BANK_W +: BANK_W]),
            .dir_q    (dir_a[k]),
            .out_q    (out_a[k]),
            .mask_q   (mask_a[k]),
            .lvl_q    (lvl_a[k]),
            .raw_q    (raw_a[k])
         );

         assign in_a[k]                        = pin_sync[k*BANK_W +: BANK_W];
         assign mstat_a[k]                     = raw_a[k] & ~mask_a[k];
         assign pin_out[k*BANK_W +: BANK_W]    = out_a[k];
         assign pin_oe[k*BANK_W +: BANK_W]     = ~dir_a[k];
         assign mask_flat[k*BANK_W +: BANK_W]  = mask_a[k];
         assign mstat_flat[k*BANK_W +: BANK_W] = mstat_a[k];
      end
   endgenerate

   assign irq = |mstat_flat;

   always_comb begin
      rd_byte = '0;
      if (in_map) begin
         case (off)
            STRIDE_LOG2'(OFF_MSTAT): rd_byte = mstat_a[bank_idx];
            STRIDE_LOG2'(OFF_RAW):   rd_byte = raw_a[bank_idx];
            STRIDE_LOG2'(OFF_MSET):  rd_byte = mask_a[bank_idx];
            STRIDE_LOG2'(OFF_DIR):   rd_byte = dir_a[bank_idx];
            STRIDE_LOG2'(OFF_OUT):   rd_byte = out_a[bank_idx];
            STRIDE_LOG2'(OFF_IN):    rd_byte = in_a[bank_idx];
            STRIDE_LOG2'(OFF_LVL):   rd_byte = lvl_a[bank_idx];
            default:                 rd_byte = '0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  bus_rdata <= '0;
      else if (bus_sel && !bus_wr) bus_rdata <= DATA_W'(rd_byte);
   end
endmodule

// File: rtl/banked_gpio_chk.sv
`timescale 1ns/1ps
module banked_gpio_chk #(
   parameter int NUM_PINS = 32,
   parameter int BANK_W   = 8,
   parameter int DATA_W   = 32
) (
   input logic                clk,
   input logic                rst_n,
   input logic                bus_sel,
   input logic                bus_wr,
   input logic [DATA_W-1:0]   bus_rdata,
   input logic [NUM_PINS-1:0] pin_out,
   input logic [NUM_PINS-1:0] pin_oe,
   input logic [NUM_PINS-1:0] mask_flat,
   input logic                irq
);
   p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!irq && pin_oe == '0 && pin_out == '0 && (&mask_flat)));

   p_oe_by_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pin_oe) |-> $past(bus_sel && bus_wr));

   p_out_by_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pin_out) |-> $past(bus_sel && bus_wr));

   p_masked_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (&mask_flat) |-> !irq);

   p_upper_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata[DATA_W-1:BANK_W] == '0);

   p_rdata_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(bus_sel && !bus_wr) |-> $stable(bus_rdata));
endmodule

bind banked_gpio banked_gpio_chk #(
   .NUM_PINS (NUM_BANKS * BANK_W),
   .BANK_W   (BANK_W),
   .DATA_W   (DATA_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_wr    (bus_wr),
   .bus_rdata (bus_rdata),
   .pin_out   (pin_out),
   .pin_oe    (pin_oe),
   .mask_flat (mask_flat),
   .irq       (irq)
);

// File: tb/banked_gpio_tb.sv
`timescale 1ns/1ps
module banked_gpio_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] pin_out, pin_oe;
   logic [31:0] pin_in = '0;
   logic        irq;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   banked_gpio u_dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_out(pin_out), .pin_oe(pin_oe), .pin_in(pin_in), .irq(irq)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   task automatic wr_reg(input int bank, input logic [7:0] off, input logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'(bank * 64) + off; bus_wdata = d;
      @(posedge clk); @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd_reg(input int bank, input logic [7:0] off, output logic [31:0] q);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 8'(bank * 64) + off;
      @(posedge clk); @(negedge clk);
      bus_sel = 1'b0;
      q = bus_rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      logic [31:0] q, q1, q2, exp_v;
      logic [7:0]  pat [4];
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state in every bank
      chk("R1 pin_oe", pin_oe, 32'h0);
      chk("R1 pin_out", pin_out, 32'h0);
      chk("R1 irq", {31'b0, irq}, 32'h0);
      for (int b = 0; b < 4; b++) begin
         rd_reg(b, 8'h10, q); chk("R1 dir", q, 32'hFF);
         rd_reg(b, 8'h14, q); chk("R1 out", q, 32'h0);
         rd_reg(b, 8'h08, q); chk("R1 mask", q, 32'hFF);
         rd_reg(b, 8'h04, q); chk("R1 raw", q, 32'h0);
         rd_reg(b, 8'h20, q); chk("R1 type", q, 32'h0);
         rd_reg(b, 8'h00, q); chk("R1 masked", q, 32'h0);
      end

      // R2 / R4: per-bank output patterns, pin n from bank n>>3 bit n&7
      for (int b = 0; b < 4; b++) begin
         pat[b] = 8'(b * 8'h35 + 8'h11);
         wr_reg(b, 8'h14, {24'h0, pat[b]});
      end
      for (int b = 0; b < 4; b++) begin
         rd_reg(b, 8'h14, q); chk("R4 out readback", q, {24'h0, pat[b]});
      end
      exp_v = '0;
      for (int n = 0; n < 32; n++) exp_v[n] = pat[n >> 3][n & 7];
      chk("R2 pin_out map", pin_out, exp_v);
      chk("R4 pin_out", pin_out, {pat[3], pat[2], pat[1], pat[0]});
      wr_reg(1, 8'h14, 32'h04);
      chk("R2 pin 10 is bank1 bit2", {31'b0, pin_out[10]}, 32'h1);
      chk("R2 bank1 only", pin_out, {pat[3], pat[2], 8'h04, pat[0]});

      // R3: direction polarity sweep
      for (int b = 0; b < 4; b++) wr_reg(b, 8'h10, 32'(8'hA5 ^ 8'(b * 17)));
      exp_v = '0;
      for (int b = 0; b < 4; b++) begin
         rd_reg(b, 8'h10, q); chk("R3 dir readback", q, 32'(8'hA5 ^ 8'(b * 17)));
         exp_v[b*8 +: 8] = ~(8'hA5 ^ 8'(b * 17));
      end
      chk("R3 pin_oe", pin_oe, exp_v);
      for (int b = 0; b < 4; b++) wr_reg(b, 8'h10, 32'h00);
      chk("R3 all outputs", pin_oe, 32'hFFFF_FFFF);
      for (int b = 0; b < 4; b++) wr_reg(b, 8'h10, 32'hFF);
      chk("R3 all inputs", pin_oe, 32'h0);

      // R5: synchronizer latency and input patterns
      pin_in = 32'h005A_0000;
      rd_reg(2, 8'h18, q);  chk("R5 first read old", q, 32'h0);
      rd_reg(2, 8'h18, q1); chk("R5 second read old", q1, 32'h0);
      rd_reg(2, 8'h18, q2); chk("R5 third read new", q2, 32'h5A);
      pin_in = 32'hC3_81_7E_24;
      idle(4);
      for (int b = 0; b < 4; b++) begin
         rd_reg(b, 8'h18, q); chk("R5 input", q, 32'(pin_in[b*8 +: 8]));
      end
      wr_reg(0, 8'h18, 32'h00);
      rd_reg(0, 8'h18, q); chk("R5 write ignored", q, 32'h24);
      pin_in = '0;
      idle(4);
      // edges raised while masked: acknowledge everything
      for (int b = 0; b < 4; b++) wr_reg(b, 8'h04, 32'hFF);

      // R8: mask set / clear
      wr_reg(0, 8'h0C, 32'hF0);
      rd_reg(0, 8'h08, q); chk("R8 mask clear", q, 32'h0F);
      rd_reg(0, 8'h0C, q); chk("R8 clear addr reads 0", q, 32'h0);
      wr_reg(0, 8'h08, 32'h30);
      rd_reg(0, 8'h08, q); chk("R8 mask set", q, 32'h3F);
      wr_reg(0, 8'h08, 32'hFF);
      rd_reg(0, 8'h08, q); chk("R8 mask all", q, 32'hFF);

      // R6: edge interrupt on every pin
      for (int b = 0; b < 4; b++) wr_reg(b, 8'h0C, 32'hFF);
      for (int n = 0; n < 32; n++) begin
         pin_in = 32'(1) << n;
         if (n == 10) begin
            idle(2); chk("R6 irq not yet", {31'b0, irq}, 32'h0);
            idle(1); chk("R6 irq on third edge", {31'b0, irq}, 32'h1);
            idle(1);
         end else idle(4);
         rd_reg(n >> 3, 8'h04, q); chk("R6 raw set", q, 32'(8'(1) << (n & 7)));
         rd_reg((n >> 3) ^ 1, 8'h04, q); chk("R6 other bank clear", q, 32'h0);
         chk("R6 irq", {31'b0, irq}, 32'h1);
         pin_in = '0;
         idle(4);
         rd_reg(n >> 3, 8'h04, q); chk("R6 raw holds", q, 32'(8'(1) << (n & 7)));
         wr_reg(n >> 3, 8'h04, 32'(~(8'(1) << (n & 7))));
         rd_reg(n >> 3, 8'h04, q); chk("R6 zero bits keep", q, 32'(8'(1) << (n & 7)));
         wr_reg(n >> 3, 8'h04, 32'(8'(1) << (n & 7)));
         chk("R6 irq after ack", {31'b0, irq}, 32'h0);
         rd_reg(n >> 3, 8'h04, q); chk("R6 raw cleared", q, 32'h0);
      end

      // R7: level type on pin 21 (bank 2 bit 5)
      wr_reg(2, 8'h20, 32'h20);
      rd_reg(2, 8'h20, q); chk("R7 type readback", q, 32'h20);
      pin_in = 32'h0020_0000;
      idle(4);
      rd_reg(2, 8'h04, q); chk("R7 level raw", q, 32'h20);
      wr_reg(2, 8'h04, 32'h20);
      rd_reg(2, 8'h04, q); chk("R7 ack blocked", q, 32'h20);
      chk("R7 irq", {31'b0, irq}, 32'h1);
      pin_in = '0;
      idle(4);
      rd_reg(2, 8'h04, q); chk("R7 drops with level", q, 32'h0);
      chk("R7 irq low", {31'b0, irq}, 32'h0);
      wr_reg(2, 8'h20, 32'h00);

      // R9: masked status
      wr_reg(1, 8'h08, 32'hF0);
      pin_in = 32'h0000_3300;
      idle(4);
      pin_in = '0;
      idle(4);
      rd_reg(1, 8'h04, q); chk("R9 raw", q, 32'h33);
      rd_reg(1, 8'h00, q); chk("R9 masked", q, 32'h03);
      wr_reg(1, 8'h00, 32'hFF);
      rd_reg(1, 8'h00, q); chk("R9 write ignored", q, 32'h03);
      wr_reg(1, 8'h04, 32'hFF);
      rd_reg(1, 8'h00, q); chk("R9 cleared", q, 32'h0);

      // R10: masked cause does not reach irq until unmasked
      for (int b = 0; b < 4; b++) wr_reg(b, 8'h08, 32'hFF);
      pin_in = 32'h8000_0000;
      idle(4);
      chk("R10 masked irq", {31'b0, irq}, 32'h0);
      wr_reg(3, 8'h0C, 32'h80);
      chk("R10 unmasked irq", {31'b0, irq}, 32'h1);
      wr_reg(3, 8'h08, 32'h80);
      chk("R10 remasked irq", {31'b0, irq}, 32'h0);
      pin_in = '0;
      idle(4);
      wr_reg(3, 8'h04, 32'hFF);

      // R11: upper bits and unmapped offsets
      wr_reg(0, 8'h14, 32'hFFFF_FFFF);
      rd_reg(0, 8'h14, q); chk("R11 upper bits zero", q, 32'hFF);
      wr_reg(2, 8'h1C, 32'hAA);
      wr_reg(2, 8'h24, 32'hAA);
      wr_reg(2, 8'h15, 32'hAA);
      rd_reg(2, 8'h1C, q); chk("R11 unmapped 0x1C", q, 32'h0);
      rd_reg(2, 8'h3C, q); chk("R11 unmapped 0x3C", q, 32'h0);
      rd_reg(2, 8'h15, q); chk("R11 unaligned", q, 32'h0);
      rd_reg(2, 8'h14, q); chk("R11 out untouched", q, 32'(pat[2]));
      rd_reg(2, 8'h10, q); chk("R11 dir untouched", q, 32'hFF);
      rd_reg(2, 8'h20, q); chk("R11 type untouched", q, 32'h0);

      // R12: read data holds across writes
      rd_reg(0, 8'h14, q);
      wr_reg(0, 8'h14, 32'h12);
      wr_reg(1, 8'h10, 32'h00);
      chk("R12 rdata held", bus_rdata, 32'hFF);
      rd_reg(0, 8'h14, q); chk("R12 new read", q, 32'h12);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end
endmodule